// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

This block is a serial transmitter and receiver for asynchronous links. It has two frame formats. The short format carries eight data bits between a start bit and a stop bit. The long format adds a ninth data bit, which is sent right after data bit 7. The 2-bit `mode` input selects the format and the rate source. Mode 2 takes its bit rate from a fixed divide of the system clock. Modes 1 and 3 take their bit timing from single-cycle overflow pulses of an external timer.

The transmitter has a single buffer. Software writes a byte and its ninth bit with a one-cycle strobe. A done flag rises near the end of the frame.

The receiver decides each bit by a two-out-of-three majority vote on samples taken around the middle of the bit. It throws away start edges that do not hold low. It is double buffered: a finished frame moves into a holding register with a ready flag, so the next frame can arrive before the previous one is read.

Top module: `serial_port`

## Requirements
- R1: In mode 1 (`mode` = 1; the value 0 behaves the same way), a transmitted frame has 10 bits: a low start bit, then data bits 0 to 7 in order (LSB first), then a high stop bit. The line idles high.
- R2: In modes 2 and 3, a frame has 11 bits: a low start bit, data bits 0 to 7 in order, the ninth bit, then a high stop bit.
- R3: In mode 2, one bit lasts 64 system clock cycles. In modes 1 and 3, one bit lasts 16 `ovf_pulse` pulses, so each pulse is one sample tick.
- R4: `tx_done` goes high in the middle of the stop bit. It goes low when a write is accepted.
- R5: A `tx_wr` strobe that arrives while a frame is still being sent is ignored, and the frame on `txd` does not change.
- R6: Each received bit takes the majority value of three samples taken on ticks 7, 8 and 9 of that bit. A glitch that corrupts one sample does not change the received data.
- R7: A low level on `rxd` that is no longer low at the start-bit vote is discarded. The receiver goes back to idle, raises no ready flag, and then receives the next valid frame correctly.
- R8: When a received frame completes, `rx_data` and `rx_bit9` are loaded and `rx_ready` goes high. In the long format, `rx_bit9` holds the ninth data bit; in mode 1 it holds the received stop bit. An `rx_rd` strobe clears `rx_ready`.
- R9: If a frame completes while `rx_ready` is still high, the holding register takes the new frame and `rx_overrun` goes high. `rx_rd` clears both `rx_ready` and `rx_overrun`.
- R10: After reset, `txd` is high and `tx_done`, `rx_ready` and `rx_overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Frame and rate select (1, 2 or 3) |
| ovf_pulse | input | 1 | Single-cycle timer overflow pulse; one sample tick in modes 1 and 3 |
| tx_wr | input | 1 | One-cycle write strobe for the transmitter |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in the long format |
| txd | output | 1 | Serial output line |
| tx_done | output | 1 | Transmit-done flag |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_rd | input | 1 | One-cycle read strobe for the holding register |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit (stop bit in mode 1) |
| rx_ready | output | 1 | Holding register contains an unread frame |
| rx_overrun | output | 1 | A frame overwrote an unread one |

## Verification
The assertions assume the following about the inputs:
- `mode` stays constant while a frame is in flight.
- `ovf_pulse` is high for at most one cycle per tick.
- `tx_wr` and `rx_rd` are one-cycle strobes.
- A read strobe never lands in the same cycle that a frame completes.

The stimulus keeps to these rules. It changes `mode` only between frames, when both sides are idle. It drives the overflow pulse high on every second cycle. It issues reads only after a received frame has fully ended, and it places line glitches so that they cover at most one of the three vote samples.

// File: rtl/sp_pkg.sv
// Shared types and helpers for the serial port.
// Assumes nothing beyond IEEE 1800-2017.
package sp_pkg;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    // Majority of three samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/sp_tick.sv
// Sample-tick source: a fixed clock divide in mode 2, the external overflow
// pulse otherwise. Assumes CLK_PER_BIT is a multiple of OVS.
module sp_tick #(
    parameter int CLK_PER_BIT = 64,
    parameter int OVS         = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ovf_pulse,
    output logic       tick
);
    localparam int DIV = CLK_PER_BIT / OVS;
    localparam int W   = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;
    logic         fixed_tick;

    assign fixed_tick = (cnt == W'(DIV - 1));

    // Free-running divider for the fixed-rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (fixed_tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Pick the tick source from the mode.
    always_comb tick = (mode == 2'd2) ? fixed_tick : ovf_pulse;

    generate
        if (DIV > 1) begin : g_gap
            assert_fixed_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == 2'd2 && tick) |=> !fixed_tick);
        end
    endgenerate
endmodule

// File: rtl/sp_tx.sv
// Single-buffered transmitter. A write is accepted only while idle; the
// frame goes out LSB first, with the ninth bit in the long format.
// Assumes long_frame is stable during a frame.
module sp_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       long_frame,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       bit9,
    output logic       txd,
    output logic       done
);
    localparam int CW = $clog2(OVS);

    logic [10:0]   sh;
    logic          busy;
    logic [CW-1:0] tcnt;
    logic [3:0]    bidx;
    logic [3:0]    last;
    logic          bit_end;
    logic          accept;

    assign last    = long_frame ? 4'd10 : 4'd9;
    assign bit_end = tick && (tcnt == CW'(OVS - 1));
    assign accept  = wr && !busy;
    assign txd     = sh[0];

    // Frame shifter with bit and tick counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            busy <= 1'b0;
            tcnt <= '0;
            bidx <= '0;
        end else if (!busy) begin
            if (wr) begin
                sh   <= long_frame ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
                busy <= 1'b1;
                tcnt <= '0;
                bidx <= '0;
            end
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (bit_end) begin
                sh   <= {1'b1, sh[10:1]};
                bidx <= bidx + 1'b1;
                if (bidx == last) busy <= 1'b0;
            end
        end
    end

    // Done flag: set mid stop bit, cleared by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      done <= 1'b0;
        else if (accept) done <= 1'b0;
        else if (busy && bidx == last && tick && tcnt == CW'(OVS / 2 - 1))
            done <= 1'b1;
    end

    assert_done_mid_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (busy && bidx == last));
    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && !bit_end) |=> $stable(txd));
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
endmodule

// File: rtl/sp_rx.sv
// Receiver with start-edge search on every tick, 3-sample majority vote on
// ticks 7/8/9, false-start rejection and a holding register.
// Assumes rxd is asynchronous (synchronised here) and rd is a strobe.
module sp_rx
    import sp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       long_frame,
    input  logic       rxd,
    input  logic       rd,
    output logic [7:0] data,
    output logic       bit9,
    output logic       ready,
    output logic       overrun
);
    localparam int CW = $clog2(OVS);

    rx_state_t     state;
    logic [1:0]    sync;
    logic          rx_s;
    logic [CW-1:0] tcnt;
    logic [3:0]    idx;
    logic          s7, s8;
    logic [8:0]    bits;
    logic          vote_pt, vote, bit_end, load;

    assign rx_s    = sync[1];
    assign vote_pt = tick && (tcnt == CW'(OVS / 2 + 1));
    assign bit_end = tick && (tcnt == CW'(OVS - 1));
    assign vote    = maj3(s7, s8, rx_s);
    assign load    = (state == RX_STOP) && vote_pt;

    // Two-flop synchroniser on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Frame state machine, tick counter and vote samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            s7    <= 1'b1;
            s8    <= 1'b1;
            bits  <= '0;
        end else if (state == RX_IDLE) begin
            if (tick && !rx_s) begin
                state <= RX_START;
                tcnt  <= CW'(1);
            end
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (tcnt == CW'(OVS / 2 - 1)) s7 <= rx_s;
            if (tcnt == CW'(OVS / 2))     s8 <= rx_s;
            case (state)
                RX_START: begin
                    if (vote_pt && vote) state <= RX_IDLE;
                    else if (bit_end) begin
                        state <= RX_DATA;
                        idx   <= '0;
                    end
                end
                RX_DATA: begin
                    if (vote_pt) bits[idx] <= vote;
                    if (bit_end) begin
                        if (idx == (long_frame ? 4'd8 : 4'd7)) state <= RX_STOP;
                        else                                    idx   <= idx + 1'b1;
                    end
                end
                RX_STOP: if (vote_pt) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Holding register with ready and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data    <= '0;
            bit9    <= 1'b0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else if (load) begin
            data    <= bits[7:0];
            bit9    <= long_frame ? bits[8] : vote;
            ready   <= 1'b1;
            overrun <= rd ? 1'b0 : (ready | overrun);
        end else if (rd) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end
    end

    assert_false_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && vote_pt && vote && !rd) |=> $stable(ready));
    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(ready));
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> (!ready && !overrun));
    assert_vote_unanimous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && vote_pt && s7 == s8 && s8 == rx_s) |=> bits[$past(idx)] == $past(rx_s));
endmodule

// File: rtl/serial_port.sv
// Top of the multi-mode serial port: tick source, transmitter and receiver.
// Assumes mode is changed only while both directions are idle.
module serial_port #(
    parameter int CLK_PER_BIT = 64,
    parameter int OVS         = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ovf_pulse,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       tx_bit9,
    output logic       txd,
    output logic       tx_done,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_ready,
    output logic       rx_overrun
);
    logic tick;
    logic long_frame;

    assign long_frame = mode[1];

    sp_tick #(.CLK_PER_BIT(CLK_PER_BIT), .OVS(OVS)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ovf_pulse(ovf_pulse), .tick(tick)
    );

    sp_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .long_frame(long_frame),
        .wr(tx_wr), .data(tx_data), .bit9(tx_bit9), .txd(txd), .done(tx_done)
    );

    sp_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .long_frame(long_frame),
        .rxd(rxd), .rd(rx_rd), .data(rx_data), .bit9(rx_bit9),
        .ready(rx_ready), .overrun(rx_overrun)
    );
endmodule

// File: tb/serial_port_test.sv
// Directed bench for serial_port: one task per scenario.
module serial_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd2;
    logic       ovf_pulse = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_bit9 = 1'b0;
    logic       txd, tx_done;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, rx_overrun;

    int checks = 0;
    int errors = 0;

    localparam int BIT_M2  = 64;
    localparam int BIT_OVF = 32;

    serial_port uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ovf_pulse(ovf_pulse),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9), .txd(txd),
        .tx_done(tx_done), .rxd(rxd), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
    );

    always #5 clk = ~clk;

    // Overflow pulse on every second cycle: 16 pulses = 32 cycles per bit.
    initial forever begin
        @(negedge clk);
        ovf_pulse = ~ovf_pulse;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Transmit one frame and sample every bit in its middle; optionally write mid-frame.
    task automatic tx_frame(input logic [1:0] m, input logic [7:0] d, input logic b9,
                            input bit inject, input string req);
        int nbits = m[1] ? 11 : 10;
        int bl    = (m == 2'd2) ? BIT_M2 : BIT_OVF;
        logic [10:0] fr = m[1] ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
        mode = m;
        @(negedge clk);
        tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        for (int c = 1; c <= nbits * bl; c++) begin
            @(negedge clk);
            tx_wr = 1'b0;
            if (inject && c == 2 * bl + 5) begin
                tx_data = ~d; tx_bit9 = ~b9; tx_wr = 1'b1;
            end
            if (c % bl == bl / 2 && c / bl < nbits)
                check(txd == fr[c / bl], req, txd, fr[c / bl]);
            if (c == (nbits - 1) * bl + bl / 4)
                check(tx_done == 1'b0, "R4 done low before mid stop", tx_done, 0);
            if (c == (nbits - 1) * bl + 3 * bl / 4)
                check(tx_done == 1'b1, "R4 done high after mid stop", tx_done, 1);
        end
        tx_wr = 1'b0;
        repeat (bl) @(negedge clk);
        check(txd == 1'b1, "R1 idle line high", txd, 1);
    endtask

    // Accepted write clears the done flag.
    task automatic tx_clear_done();
        check(tx_done == 1'b1, "R4 done before write", tx_done, 1);
        mode = 2'd2;
        @(negedge clk);
        tx_data = 8'h11; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check(tx_done == 1'b0, "R4 write clears done", tx_done, 0);
        repeat (12 * BIT_M2) @(negedge clk);
    endtask

    // Drive one frame on rxd; glitch_bit >= 0 inverts 3 cycles in that bit.
    task automatic rx_send(input logic [1:0] m, input logic [7:0] d, input logic b9,
                           input logic stopv, input int glitch_bit);
        int nbits = m[1] ? 11 : 10;
        int bl    = (m == 2'd2) ? BIT_M2 : BIT_OVF;
        logic [10:0] fr = m[1] ? {stopv, b9, d, 1'b0} : {1'b1, stopv, d, 1'b0};
        mode = m;
        for (int k = 0; k < nbits; k++) begin
            for (int c = 0; c < bl; c++) begin
                @(negedge clk);
                if (k == glitch_bit && c >= bl / 2 - 1 && c < bl / 2 + 2) rxd = ~fr[k];
                else rxd = fr[k];
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic rx_read();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        check(rx_ready == 1'b0, "R8 read clears ready", rx_ready, 0);
        check(rx_overrun == 1'b0, "R9 read clears overrun", rx_overrun, 0);
    endtask

    task automatic rx_expect(input logic [7:0] d, input logic b9, input string req);
        check(rx_ready == 1'b1, req, rx_ready, 1);
        check(rx_data == d, req, rx_data, d);
        check(rx_bit9 == b9, req, rx_bit9, b9);
    endtask

    task automatic test_reset();
        check(txd == 1'b1, "R10 txd", txd, 1);
        check(tx_done == 1'b0, "R10 tx_done", tx_done, 0);
        check(rx_ready == 1'b0, "R10 rx_ready", rx_ready, 0);
        check(rx_overrun == 1'b0, "R10 rx_overrun", rx_overrun, 0);
    endtask

    task automatic test_false_start();
        mode = 2'd2;
        @(negedge clk);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_M2) @(negedge clk);
        check(rx_ready == 1'b0, "R7 false start gives no frame", rx_ready, 0);
        rx_send(2'd2, 8'h96, 1'b0, 1'b1, -1);
        rx_expect(8'h96, 1'b0, "R7 frame after false start");
        rx_read();
    endtask

    task automatic test_overrun();
        rx_send(2'd2, 8'h01, 1'b1, 1'b1, -1);
        check(rx_overrun == 1'b0, "R9 no overrun on first", rx_overrun, 0);
        rx_send(2'd2, 8'hFE, 1'b0, 1'b1, -1);
        check(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
        rx_expect(8'hFE, 1'b0, "R9 newest frame kept");
        rx_read();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        tx_frame(2'd2, 8'hA5, 1'b1, 1'b0, "R2 R3 mode 2 tx bit");
        tx_frame(2'd1, 8'h3C, 1'b0, 1'b0, "R1 R3 mode 1 tx bit");
        tx_frame(2'd3, 8'h5A, 1'b0, 1'b1, "R5 write during frame ignored");
        tx_clear_done();
        rx_send(2'd2, 8'hC3, 1'b1, 1'b1, -1);
        rx_expect(8'hC3, 1'b1, "R8 mode 2 rx");
        rx_read();
        rx_send(2'd3, 8'h4D, 1'b0, 1'b1, -1);
        rx_expect(8'h4D, 1'b0, "R8 R3 mode 3 rx");
        rx_read();
        rx_send(2'd1, 8'hB2, 1'b0, 1'b1, -1);
        rx_expect(8'hB2, 1'b1, "R8 mode 1 bit9 is stop bit");
        rx_read();
        rx_send(2'd2, 8'h24, 1'b0, 1'b1, 3);
        rx_expect(8'h24, 1'b0, "R6 glitch on a one bit");
        rx_read();
        rx_send(2'd2, 8'hFB, 1'b1, 1'b1, 3);
        rx_expect(8'hFB, 1'b1, "R6 glitch on a zero bit");
        rx_read();
        test_false_start();
        test_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule